// File: doc/BRIEF.md
# Modem Status Change Tracker

This block watches the four active-low handshake inputs of one serial channel: clear-to-send, data-set-ready, ring indicator and carrier detect. It turns them into an 8-bit status byte for the register read path. The upper nibble shows which lines are asserted right now. The lower nibble holds sticky change flags. These record what has happened on each line since software last read the byte, and a read clears them.

Each pin passes through a two-flop synchronizer and is inverted into asserted form. A loopback multiplexer then picks the source. In loopback the external pins are ignored: the request-to-send control bit drives clear-to-send, the data-terminal-ready control bit drives data-set-ready, and ring and carrier read as inactive. A registered copy of the selected levels feeds an edge detector. Clear-to-send, data-set-ready and carrier flag any change. The ring flag records only the trailing edge of a ring, which is the pin rising from low to high. The OR of the four flags drives a change-pending output for the interrupt logic.

Top module: `modem_status_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, `msr` is 8'h00 and `chg_pend` is 0, given all pins are high (inactive).
- R2: `msr[7]`, `msr[6]`, `msr[5]` and `msr[4]` report carrier, ring, data-set-ready and clear-to-send. Each bit reads 1 when its pin is low. Outside loopback, a pin change shows in `msr` after the third rising clock edge that follows it.
- R3: `msr[0]` (clear-to-send), `msr[1]` (data-set-ready) and `msr[3]` (carrier) set when their reported level changes in either direction. Each sets on the same edge that updates the level bit.
- R4: `msr[2]` sets only when the ring pin goes from low to high. A high-to-low transition of the ring pin leaves it clear.
- R5: A clock edge with `rd_stb` high clears all four change flags, unless a new change is detected on that same edge.
- R6: A change detected on the same edge as a read sets its flag, so the change is not lost.
- R7: Without a read, a set flag stays set whatever the pins do afterwards.
- R8: `chg_pend` is 1 exactly when any of `msr[3:0]` is 1.
- R9: With `loop_en` high, the pins are ignored. One edge later, `msr[4]` equals `rts_ctl`, `msr[5]` equals `dtr_ctl`, and `msr[6]` and `msr[7]` are 0. Changes of the control bits set the flags like pin changes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| rd_stb | input | 1 | One-cycle strobe: status byte is being read |
| loop_en | input | 1 | Internal loopback mode enable |
| dtr_ctl | input | 1 | Data-terminal-ready control bit, 1 = active |
| rts_ctl | input | 1 | Request-to-send control bit, 1 = active |
| msr | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |
| chg_pend | output | 1 | Change pending, request for the modem status interrupt |

## Verification
The in-line assertions check four things on every cycle. Flags stay set without a read. A read with no concurrent change empties the flags. A change on the read edge survives. The ring flag rises only together with a falling asserted ring level. They also check that loopback holds carrier and ring at zero and mirrors the request-to-send bit. Only the bench's scenarios can show the end-to-end timing: the three-edge latency from pin to status, and that pin activity during loopback leaves the byte untouched. The bench also shows that a ring pulse yields exactly one flag at its end. These need a reference model running across many cycles of mixed random and directed stimulus.

// File: rtl/mst_pkg.sv
package mst_pkg;

    localparam int LINE_CNT = 4;
    localparam int IDX_CTS  = 0;
    localparam int IDX_DSR  = 1;
    localparam int IDX_RI   = 2;
    localparam int IDX_DCD  = 3;

    // asserted-form line levels, packed in status-byte order
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    typedef enum logic {
        EDGE_ANY   = 1'b0,
        EDGE_TRAIL = 1'b1
    } edge_kind_e;

    function automatic edge_kind_e kind_of(input int idx);
        return (idx == IDX_RI) ? EDGE_TRAIL : EDGE_ANY;
    endfunction

    // prev/now are asserted levels; a trailing edge is asserted -> released
    function automatic logic edge_hit(input edge_kind_e k, input logic prev, input logic now);
        logic hit;
        case (k)
            EDGE_TRAIL: hit = prev & ~now;
            default:    hit = prev ^ now;
        endcase
        return hit;
    endfunction

    function automatic mdm_lines_t loop_source(input logic rts, input logic dtr);
        mdm_lines_t v;
        v.cts = rts;
        v.dsr = dtr;
        v.ri  = 1'b0;
        v.dcd = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/mst_loop_mux.sv
module mst_loop_mux
    import mst_pkg::*;
#(
    parameter int LINES = LINE_CNT
) (
    input  logic             loop_en,
    input  logic             rts_ctl,
    input  logic             dtr_ctl,
    input  logic [LINES-1:0] ext_lvl,
    output logic [LINES-1:0] src_lvl
);

    mdm_lines_t ext_s;
    mdm_lines_t loop_s;
    mdm_lines_t pick_s;

    always_comb begin
        ext_s  = mdm_lines_t'(ext_lvl);
        loop_s = loop_source(rts_ctl, dtr_ctl);
        pick_s = loop_en ? loop_s : ext_s;
        src_lvl = pick_s;
    end

endmodule

// File: rtl/mst_flag_track.sv
module mst_flag_track
    import mst_pkg::*;
#(
    parameter int LINES = LINE_CNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_stb,
    input  logic [LINES-1:0] src_lvl,
    output logic [LINES-1:0] lvl_q,
    output logic [LINES-1:0] flag_q
);

    logic [LINES-1:0] hit;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            localparam edge_kind_e KIND = kind_of(i);

            always_comb hit[i] = edge_hit(KIND, lvl_q[i], src_lvl[i]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl_q[i]  <= 1'b0;
                    flag_q[i] <= 1'b0;
                end else begin
                    lvl_q[i]  <= src_lvl[i];
                    flag_q[i] <= (flag_q[i] & ~rd_stb) | hit[i];
                end
            end
        end
    endgenerate

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (src_lvl == lvl_q)) |=> (flag_q == '0)); // R5

    AST_READ_RACE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (src_lvl[IDX_CTS] != lvl_q[IDX_CTS])) |=> flag_q[IDX_CTS]); // R6

    AST_RI_TRAIL_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[IDX_RI]) |-> $fell(lvl_q[IDX_RI])); // R4

endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
    import mst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    input  logic       rd_stb,
    input  logic       loop_en,
    input  logic       dtr_ctl,
    input  logic       rts_ctl,
    output logic [7:0] msr,
    output logic       chg_pend
);

    localparam int LINES = LINE_CNT;

    logic [LINES-1:0] pin_raw;
    logic [LINES-1:0] pin_sync;
    logic [LINES-1:0] ext_lvl;
    logic [LINES-1:0] src_lvl;
    logic [LINES-1:0] lvl_q;
    logic [LINES-1:0] flag_q;

    assign pin_raw = {dcd_n, ri_n, dsr_n, cts_n};

    mst_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL({LINES{1'b1}})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_raw),
        .q  (pin_sync)
    );

    assign ext_lvl = ~pin_sync;

    mst_loop_mux #(.LINES(LINES)) u_mux (
        .loop_en(loop_en),
        .rts_ctl(rts_ctl),
        .dtr_ctl(dtr_ctl),
        .ext_lvl(ext_lvl),
        .src_lvl(src_lvl)
    );

    mst_flag_track #(.LINES(LINES)) u_track (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .src_lvl(src_lvl),
        .lvl_q  (lvl_q),
        .flag_q (flag_q)
    );

    assign msr      = {lvl_q, flag_q};
    assign chg_pend = |flag_q;

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (loop_en && $past(loop_en)) |-> (!msr[7] && !msr[6])); // R9

    AST_LOOP_CTS: assert property (@(posedge clk) disable iff (rst)
        loop_en |=> (msr[4] == $past(rts_ctl))); // R9

endmodule

// File: tb/sim_modem_status_tracker.sv
module sim_modem_status_tracker;

    logic clk = 1'b0;
    logic rst;
    logic cts_n, dsr_n, ri_n, dcd_n;
    logic rd_stb, loop_en, dtr_ctl, rts_ctl;
    logic [7:0] msr;
    logic chg_pend;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // reference model state (asserted form, status-byte order)
    logic [3:0] m_s1, m_s2, m_lvl, m_flag;

    always #10 clk = ~clk;

    modem_status_tracker u0 (
        .clk(clk), .rst(rst),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .rd_stb(rd_stb), .loop_en(loop_en), .dtr_ctl(dtr_ctl), .rts_ctl(rts_ctl),
        .msr(msr), .chg_pend(chg_pend)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, got %0d cycles exp < 100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [3:0] detect(input logic [3:0] prev, input logic [3:0] now);
        logic [3:0] d;
        d    = prev ^ now;
        d[2] = prev[2] & ~now[2];
        return d;
    endfunction

    function automatic logic [7:0] exp_msr();
        return {m_lvl, m_flag};
    endfunction

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // model update for the coming edge, then move to the next falling edge
    task automatic tick();
        logic [3:0] pins, cur;
        pins = ~{dcd_n, ri_n, dsr_n, cts_n};
        cur  = loop_en ? {2'b00, dtr_ctl, rts_ctl} : m_s2;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_lvl = '0; m_flag = '0;
        end else begin
            m_flag = (rd_stb ? 4'b0 : m_flag) | detect(m_lvl, cur);
            m_lvl  = cur;
            m_s2   = m_s1;
            m_s1   = pins;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        check8(tag, msr, exp_msr());
        check8({tag, " pend R8"}, {7'd0, chg_pend}, {7'd0, |m_flag});
    endtask

    task automatic set_pins(input logic [3:0] asserted);
        {dcd_n, ri_n, dsr_n, cts_n} = ~asserted;
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    initial begin
        rst = 1'b1; rd_stb = 1'b0; loop_en = 1'b0; dtr_ctl = 1'b0; rts_ctl = 1'b0;
        set_pins(4'b0000);
        m_s1 = '0; m_s2 = '0; m_lvl = '0; m_flag = '0;
        @(negedge clk);
        tick(); tick();
        check8("R1 reset", msr, 8'h00);
        rst = 1'b0;
        tick();
        check8("R1 after reset", msr, 8'h00);
        check8("R1 pend", {7'd0, chg_pend}, 8'h00);

        // R2/R3: assert CTS, level and flag appear after third edge
        set_pins(4'b0001);
        tick(); tick();
        check8("R2 not yet visible", msr, 8'h00);
        tick();
        check8("R2 cts level", msr[7:4], 8'h1);
        check8("R3 cts flag", msr[3:0], 8'h1);
        check8("R8 pend on", {7'd0, chg_pend}, 8'h01);

        // R7: flag sticks when pin returns high without read
        set_pins(4'b0000);
        repeat (5) tick();
        check8("R7 sticky", msr, 8'h01);
        do_read();
        check8("R5 read clears", msr, 8'h00);
        check8("R8 pend off", {7'd0, chg_pend}, 8'h00);

        // R4: ring pulse - assertion gives no flag, release sets bit 2
        set_pins(4'b0100);
        repeat (4) tick();
        check8("R4 ri lead no flag", msr, 8'h40);
        set_pins(4'b0000);
        repeat (4) tick();
        check8("R4 ri trail flag", msr, 8'h04);
        do_read();

        // R3: DSR and DCD, both directions
        set_pins(4'b1010);
        repeat (4) tick();
        check8("R3 dsr dcd set", msr, 8'hAA);
        do_read();
        set_pins(4'b0000);
        repeat (4) tick();
        check8("R3 dsr dcd release", msr, 8'h0A);
        do_read();
        check8("R5 clear again", msr, 8'h00);

        // R6: change lands on the read edge
        set_pins(4'b0001);
        tick(); tick();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
        check8("R6 race kept", msr, 8'h11);
        check_all("R6 model");
        do_read();

        // R9: loopback ignores pins, mirrors control bits
        loop_en = 1'b1; rts_ctl = 1'b1; dtr_ctl = 1'b0;
        tick();
        check8("R9 loop cts", msr[7:4], 8'h1);
        do_read();
        set_pins(4'b1111);
        repeat (4) tick();
        check8("R9 pins ignored", msr, 8'h10);
        dtr_ctl = 1'b1;
        tick();
        check8("R9 dtr->dsr", msr, 8'h32);
        loop_en = 1'b0;
        repeat (4) tick();
        check_all("R9 exit loop");
        do_read();

        // random phase with fixed seed
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 4) == 0) {dcd_n, ri_n, dsr_n, cts_n} = 4'($urandom);
            rd_stb  = (($urandom % 5) == 0);
            if (($urandom % 50) == 0) loop_en = ~loop_en;
            dtr_ctl = (($urandom % 8) == 0) ? ~dtr_ctl : dtr_ctl;
            rts_ctl = (($urandom % 8) == 0) ? ~rts_ctl : rts_ctl;
            tick();
            check8("R2 random levels", {4'd0, msr[7:4]}, {4'd0, m_lvl});
            check8("R3 random flags", {4'd0, msr[3:0]}, {4'd0, m_flag});
            check8("R8 random pend", {7'd0, chg_pend}, {7'd0, |m_flag});
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule